// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous host read and write a byte-wide asynchronous static RAM of 128K locations. The host raises a single-cycle request with a write flag, an address and write data. When the access is finished, the block returns a one-cycle done pulse, and after a read the fetched byte. On the memory side the block drives the address, the active-low chip select, write enable and output enable, and a split data bus. The split bus has an output value, a drive enable and an input value.

The memory's timing minimums are parameters in nanoseconds, and the clock period is also a parameter. The block turns each minimum into a whole number of clock cycles at elaboration. Every access runs through the same five phases: idle, setup, strobe, hold, recover. Every memory-side output comes straight from a flop. A build option keeps output enable low during writes. In that case the write pulse is stretched so that the memory's output drivers have time to turn off before the data must be valid.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset, chip select, write enable and output enable are high, and the drive enable, done, error flag and read data are all 0.
- R2: A read holds chip select and output enable low, with write enable high, for N_RD = max(cyc(T_AA), cyc(T_OE)) cycles. The read data output takes the memory byte in the clock edge that ends this window.
- R3: A write holds chip select and write enable low for N_WR cycles. With the default option (OE_LOW_WR = 0), output enable stays high for the whole write.
- R4: With OE_LOW_WR = 1, output enable is low together with write enable. The write pulse then lasts max(cyc(max(T_WP, T_WHZ+T_DW)), cyc(T_DW), cyc(T_AW)-1) cycles.
- R5: The data drive enable is high only for writes. It goes high with write enable falling and stays high for exactly one cycle after write enable rises. While it is high, the driven byte equals the host's write data. It is never high while the memory outputs are enabled.
- R6: The memory address is loaded one cycle before the strobes fall. It does not change while chip select is low.
- R7: After the strobes rise, one hold cycle follows, then REC = max(1, cyc(T_RC or T_WC) - N - 2) recovery cycles. Done is high for exactly the cycle that follows the recovery.
- R8: A request that arrives while an access is in progress is ignored: it changes no memory content and no timing. It sets an error flag that stays set until reset.
- R9: cyc(x) = ceil(x / CLK_NS), with a minimum of 1. With CLK_NS = 2 and the default timings, a default write pulse is 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request strobe, one cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host address |
| req_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Last read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag for a request made while busy |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The stimulus uses several patterns, and each one separates a different group of faults:
- Writes to the lowest address, the highest address and an alternating-bit address, followed by reads of the same addresses. This exposes lost or shifted address and data bits.
- A read of a location never written. This shows that read data comes from the memory and is not left over from an earlier access.
- A write issued with no gap after the previous done, and a write followed at once by a read. These exercise bus turnaround.
- A request injected in the middle of a write. This separates correct rejection and error flagging from a corrupted access.
- A second instance built with output enable held low during writes. This checks that its pulse is stretched beyond the default width.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 2,
  parameter int T_AA      = 10,
  parameter int T_OE      = 5,
  parameter int T_RC      = 10,
  parameter int T_WC      = 10,
  parameter int T_WP      = 7,
  parameter int T_AW      = 7,
  parameter int T_DW      = 5,
  parameter int T_WHZ     = 5,
  parameter int OE_LOW_WR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WP_NS  = (OE_LOW_WR != 0) ? imax(T_WP, T_WHZ + T_DW) : T_WP;
  localparam int RD_N   = imax(cyc(T_AA), cyc(T_OE));
  localparam int WR_N   = imax(imax(cyc(WP_NS), cyc(T_DW)), cyc(T_AW) - 1);
  localparam int RD_REC = imax(1, cyc(T_RC) - RD_N - 2);
  localparam int WR_REC = imax(1, cyc(T_WC) - WR_N - 2);
  localparam int CNT_W  = $clog2(imax(imax(RD_N, WR_N), imax(RD_REC, WR_REC)) + 1);
  localparam logic OE_WR = (OE_LOW_WR == 0);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_REC} st_t;

  st_t              st;
  logic             op_wr;
  logic [CNT_W-1:0] cnt;

  wire cnt_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_wr      <= 1'b0;
      cnt        <= '0;
      rd_data    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req && st != S_IDLE) err <= 1'b1;
      case (st)
        S_IDLE: if (req) begin
          st         <= S_SETUP;
          op_wr      <= req_wr;
          mem_addr   <= req_addr;
          mem_dq_out <= req_wdata;
        end
        S_SETUP: begin
          st       <= S_STROBE;
          mem_cs_n <= 1'b0;
          if (op_wr) begin
            mem_we_n  <= 1'b0;
            mem_oe_n  <= OE_WR;
            mem_dq_oe <= 1'b1;
            cnt       <= CNT_W'(WR_N - 1);
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_N - 1);
          end
        end
        S_STROBE: if (cnt_end) begin
          st       <= S_HOLD;
          mem_cs_n <= 1'b1;
          mem_we_n <= 1'b1;
          mem_oe_n <= 1'b1;
          if (!op_wr) rd_data <= mem_dq_in;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          st        <= S_REC;
          mem_dq_oe <= 1'b0;
          cnt       <= op_wr ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
        end
        S_REC: if (cnt_end) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_read_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_wr && !mem_cs_n) |-> mem_we_n);

  p_oe_high_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (OE_LOW_WR == 0 && !mem_we_n) |-> mem_oe_n);

  p_drive_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> op_wr);

  p_bus_free_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_we_n) |-> !mem_dq_oe);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
  localparam int CLK_NS = 2;
  localparam int AW = 17;
  localparam int DW = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD   = imax(cyc(10), cyc(5));
  localparam int N_WR   = imax(imax(cyc(7), cyc(5)), cyc(7) - 1);
  localparam int N_WR2  = imax(imax(cyc(10), cyc(5)), cyc(7) - 1);
  localparam int REC_RD = imax(1, cyc(10) - N_RD - 2);
  localparam int REC_WR = imax(1, cyc(10) - N_WR - 2);

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, over = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic done, err, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] o2_rd, o2_dq_out;
  logic o2_done, o2_err, o2_cs_n, o2_we_n, o2_oe_n, o2_dq_oe;
  logic [AW-1:0] o2_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS)) dut_i (
    .clk, .rst_n, .req, .req_wr, .req_addr, .req_wdata, .rd_data, .done, .err,
    .mem_addr, .mem_cs_n, .mem_we_n, .mem_oe_n, .mem_dq_out, .mem_dq_oe, .mem_dq_in);

  sram_async_ctrl #(.CLK_NS(CLK_NS), .OE_LOW_WR(1)) dut_oe_i (
    .clk, .rst_n, .req, .req_wr, .req_addr, .req_wdata, .rd_data(o2_rd), .done(o2_done),
    .err(o2_err), .mem_addr(o2_addr), .mem_cs_n(o2_cs_n), .mem_we_n(o2_we_n),
    .mem_oe_n(o2_oe_n), .mem_dq_out(o2_dq_out), .mem_dq_oe(o2_dq_oe), .mem_dq_in(8'h00));

  int vectors = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model
  logic [DW-1:0] sram [int];
  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) sram[int'(mem_addr)] = mem_dq_out;
    mem_dq_in <= (!mem_cs_n && !mem_oe_n && mem_we_n)
                 ? (sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00) : 8'h00;
  end

  // reference model
  logic [DW-1:0] ref_mem [int];
  logic m_busy = 0, m_wr = 0, m_done = 0, m_err = 0;
  int m_t = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_done <= 1'b0;
      if (req && m_busy) m_err <= 1'b1;
      if (m_busy) begin
        if (m_t == (m_wr ? N_WR + 1 + REC_WR : N_RD + 1 + REC_RD)) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
        end else m_t <= m_t + 1;
        if (!m_wr && m_t == N_RD)
          m_rd <= ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 8'h00;
      end else if (req) begin
        m_busy <= 1'b1; m_t <= 0; m_wr <= req_wr; m_addr <= req_addr; m_wd <= req_wdata;
        if (req_wr) ref_mem[int'(req_addr)] = req_wdata;
      end
    end
  end

  int run1 = 0, run2 = 0;
  always @(negedge clk) begin
    if (rst_n && run && !over) begin
      automatic logic stb = m_busy && m_t >= 1 && m_t <= (m_wr ? N_WR : N_RD);
      automatic logic drv = m_busy && m_wr && m_t >= 1 && m_t <= N_WR + 1;
      chk("R2 cs_n", mem_cs_n, !stb);
      chk("R3 we_n", mem_we_n, !(stb && m_wr));
      chk("R3 oe_n", mem_oe_n, !(stb && !m_wr));
      chk("R5 dq_oe", mem_dq_oe, drv);
      chk("R7 done", done, m_done);
      chk("R8 err", err, m_err);
      chk("R2 rd_data", rd_data, m_rd);
      if (m_busy) chk("R6 addr", mem_addr, m_addr);
      if (mem_dq_oe) chk("R5 dq_out", mem_dq_out, m_wd);
      if (mem_dq_oe && !mem_oe_n && !mem_cs_n && mem_we_n) chk("R5 contention", 1, 0);
      if (!mem_we_n) run1++;
      else if (run1 != 0) begin chk("R9 we pulse", run1, N_WR); run1 = 0; end
      if (!o2_we_n) begin run2++; chk("R4 oe low in write", o2_oe_n, 0); end
      else if (run2 != 0) begin chk("R4 stretched pulse", run2, N_WR2); run2 = 0; end
    end
  end

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
    @(negedge clk); req = 1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk); req = 0;
    while (!done) @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    over = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n", mem_cs_n, 1); chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n, 1); chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 done", done, 0); chk("R1 err", err, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1; run = 1;
    @(negedge clk);
    chk("R1 after reset cs_n", mem_cs_n, 1);
    op(1, 17'h00000, 8'h5A, 4);
    op(1, 17'h1FFFF, 8'hC3, 4);
    op(1, 17'h0AAAA, 8'h81, 4);
    op(0, 17'h00000, 8'h00, 4);
    op(0, 17'h1FFFF, 8'h00, 4);
    op(0, 17'h0AAAA, 8'h00, 4);
    op(0, 17'h00123, 8'h00, 4);
    // R8: request injected during a write
    @(negedge clk); req = 1; req_wr = 1; req_addr = 17'h00010; req_wdata = 8'h11;
    @(negedge clk); req = 0;
    repeat (2) @(negedge clk);
    req = 1; req_wr = 1; req_addr = 17'h00020; req_wdata = 8'h22;
    @(negedge clk); req = 0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R8 err set", err, 1);
    op(0, 17'h00020, 8'h00, 4);
    op(0, 17'h00010, 8'h00, 4);
    // turnaround: write then read without gap
    op(1, 17'h15555, 8'h3C, 0);
    op(0, 17'h15555, 8'h00, 4);
    op(1, 17'h00001, 8'hFF, 0);
    op(1, 17'h00002, 8'h00, 0);
    op(0, 17'h00001, 8'h00, 4);
    op(0, 17'h00002, 8'h00, 4);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule